// File: doc/BRIEF.md
# Comparator-driven set/reset latch controller

This block keeps one bit of state, a set/reset latch, that two comparator outputs and software can both drive. Comparator 1 can set the latch and comparator 2 can reset it. Each path has its own enable in an 8-bit control register. Software can also set or clear the latch directly. It does this by writing 1 to a pulse bit, which fires a single-cycle request and then clears itself.

Each of the two output pins has its own selector. The selector routes either the latch state or that pin's raw comparator output to the pin. The comparator status outputs always pass the true comparator levels through, whatever the latch or the pin selection is doing. The comparators, pin drivers and status registers sit outside this block.

Top module: `sr_latch_ctrl`

## Requirements
- R1: After reset `rd_data_o` is 0 and `latch_q_o` is 0. With both pin selectors at 0, `pin_o` follows `cmp_i`.
- R2: A write stores bits 7..4 of `wr_data_i`. `rd_data_o` returns those four bits in the same positions, and bits 3..0 always read 0.
- R3: With bit 5 set, a high `cmp_i[0]` sets `latch_q_o` at the next rising edge.
- R4: With bit 5 clear, `cmp_i[0]` has no effect on `latch_q_o`.
- R5: With bit 4 set, a high `cmp_i[1]` clears `latch_q_o` at the next rising edge.
- R6: With bit 4 clear, `cmp_i[1]` has no effect on `latch_q_o`.
- R7: A write with bit 3 set raises a set request for exactly one cycle, in the cycle after the write. `latch_q_o` therefore becomes 1 after the second rising edge that counts from the write. A write with bit 3 clear has no effect on the latch.
- R8: A write with bit 2 set does the same as R7, but the request clears the latch.
- R9: When set and reset requests are active in the same cycle, the latch is cleared.
- R10: `pin_o[0]` carries `latch_q_o` when bit 6 is 1 and `cmp_i[0]` when bit 6 is 0. `pin_o[1]` makes the same choice between `latch_q_o` and `cmp_i[1]` under bit 7.
- R11: `cmp_status_o` equals `cmp_i` at all times.
- R12: With no active set or reset request, `latch_q_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data |
| cmp_i | input | 2 | Synchronous comparator levels; [0] is comparator 1, [1] is comparator 2 |
| cmp_status_o | output | 2 | True comparator levels |
| latch_q_o | output | 1 | Latch state |
| pin_o | output | 2 | Pin outputs; [0] pairs with comparator 1, [1] with comparator 2 |

## Verification
Assertions run on every cycle and cover the latch update rules: reset priority, setting, holding and the reset state. They also check that a pulse request only ever follows a write that carried the matching bit, and that the read value changes only after a write. Some behaviour can only be shown by the bench's scenarios. This includes the exact two-edge delay of the software pulses, the fact that a disabled comparator path leaves the latch alone, the read-back layout, and both pin selections observed at the pins.

// File: rtl/sr_latch_pkg.sv
package sr_latch_pkg;
  localparam int unsigned REG_W = 8;
  localparam int unsigned NUM_CMP = 2;
  localparam int unsigned SEL_PIN1_BIT = 6;
  localparam int unsigned SEL_PIN2_BIT = 7;
  localparam int unsigned SET_EN_BIT = 5;
  localparam int unsigned RST_EN_BIT = 4;
  localparam int unsigned PULSE_SET_BIT = 3;
  localparam int unsigned PULSE_RST_BIT = 2;

  typedef struct packed {
    logic sel_pin2;
    logic sel_pin1;
    logic set_en;
    logic rst_en;
  } srl_cfg_t;
endpackage

// File: rtl/srl_regs.sv
module srl_regs
  import sr_latch_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output srl_cfg_t         cfg_o,
  output logic             pulse_set_o,
  output logic             pulse_rst_o
);
  srl_cfg_t cfg_q;
  logic     pset_q, prst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      pset_q <= 1'b0;
      prst_q <= 1'b0;
    end else begin
      pset_q <= wr_en_i & wr_data_i[PULSE_SET_BIT];
      prst_q <= wr_en_i & wr_data_i[PULSE_RST_BIT];
      if (wr_en_i) begin
        cfg_q.sel_pin2 <= wr_data_i[SEL_PIN2_BIT];
        cfg_q.sel_pin1 <= wr_data_i[SEL_PIN1_BIT];
        cfg_q.set_en   <= wr_data_i[SET_EN_BIT];
        cfg_q.rst_en   <= wr_data_i[RST_EN_BIT];
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    rd_data_o[SEL_PIN2_BIT] = cfg_q.sel_pin2;
    rd_data_o[SEL_PIN1_BIT] = cfg_q.sel_pin1;
    rd_data_o[SET_EN_BIT]   = cfg_q.set_en;
    rd_data_o[RST_EN_BIT]   = cfg_q.rst_en;
  end

  assign cfg_o       = cfg_q;
  assign pulse_set_o = pset_q;
  assign pulse_rst_o = prst_q;

  // R7
  pulse_set_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_set_o |-> $past(wr_en_i && wr_data_i[PULSE_SET_BIT]));
  // R8
  pulse_rst_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_rst_o |-> $past(wr_en_i && wr_data_i[PULSE_RST_BIT]));
  // R2
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_en_i) |-> $stable(rd_data_o));
endmodule

// File: rtl/srl_core.sv
module srl_core
  import sr_latch_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  srl_cfg_t cfg_i,
  input  logic     cmp_set_i,
  input  logic     cmp_rst_i,
  input  logic     pulse_set_i,
  input  logic     pulse_rst_i,
  output logic     q_o
);
  logic set_req, rst_req, q_q;

  assign set_req = (cfg_i.set_en & cmp_set_i) | pulse_set_i;
  assign rst_req = (cfg_i.rst_en & cmp_rst_i) | pulse_rst_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_q <= 1'b0;
    else if (rst_req) q_q <= 1'b0;  // reset dominates
    else if (set_req) q_q <= 1'b1;
  end

  assign q_o = q_q;

  // R9
  rst_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req |=> !q_o);
  // R3
  set_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_req && !rst_req) |=> q_o);
  // R12
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_req && !rst_req) |=> $stable(q_o));
  // R1
  reset_state_chk: assert property (@(posedge clk_i)
    !rst_ni |-> !q_o);
endmodule

// File: rtl/srl_pin_mux.sv
module srl_pin_mux
  import sr_latch_pkg::*;
#(
  parameter int unsigned NUM_PINS = NUM_CMP
) (
  input  logic [NUM_PINS-1:0] sel_q_i,
  input  logic                q_i,
  input  logic [NUM_PINS-1:0] cmp_i,
  output logic [NUM_PINS-1:0] pin_o
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign pin_o[p] = sel_q_i[p] ? q_i : cmp_i[p];
  end
endmodule

// File: rtl/sr_latch_ctrl.sv
module sr_latch_ctrl
  import sr_latch_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [REG_W-1:0]   wr_data_i,
  output logic [REG_W-1:0]   rd_data_o,
  input  logic [NUM_CMP-1:0] cmp_i,
  output logic [NUM_CMP-1:0] cmp_status_o,
  output logic               latch_q_o,
  output logic [NUM_CMP-1:0] pin_o
);
  srl_cfg_t cfg;
  logic     pulse_set, pulse_rst;

  srl_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .rd_data_o  (rd_data_o),
    .cfg_o      (cfg),
    .pulse_set_o(pulse_set),
    .pulse_rst_o(pulse_rst)
  );

  srl_core u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_i      (cfg),
    .cmp_set_i  (cmp_i[0]),
    .cmp_rst_i  (cmp_i[1]),
    .pulse_set_i(pulse_set),
    .pulse_rst_i(pulse_rst),
    .q_o        (latch_q_o)
  );

  srl_pin_mux #(.NUM_PINS(NUM_CMP)) u_mux (
    .sel_q_i({cfg.sel_pin2, cfg.sel_pin1}),
    .q_i    (latch_q_o),
    .cmp_i  (cmp_i),
    .pin_o  (pin_o)
  );

  // status always shows raw comparator levels
  assign cmp_status_o = cmp_i;
endmodule

// File: tb/sr_latch_ctrl_tb_top.sv
module sr_latch_ctrl_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic [1:0] cmp_i = '0;
  logic [1:0] cmp_status_o;
  logic       latch_q_o;
  logic [1:0] pin_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  sr_latch_ctrl dut_i (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  // write lands at the next edge; returns at the following negedge
  task automatic wr(logic [7:0] d);
    wr_en_i = 1'b1; wr_data_i = d;
    step();
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic t_reset();
    chk("R1 rd", rd_data_o, 8'h00);
    chk("R1 q", {7'b0, latch_q_o}, 8'h00);
    cmp_i = 2'b11; #1;
    chk("R1 pins", {6'b0, pin_o}, 8'h03);
    chk("R11 status", {6'b0, cmp_status_o}, 8'h03);
    cmp_i = 2'b00; #1;
    chk("R1 pins low", {6'b0, pin_o}, 8'h00);
  endtask

  task automatic t_readback();
    wr(8'hFF);
    chk("R2 rd all", rd_data_o, 8'hF0);
    step();
    chk("R9 both pulses", {7'b0, latch_q_o}, 8'h00);
    wr(8'h50);
    chk("R2 rd 50", rd_data_o, 8'h50);
    wr(8'h00);
    chk("R2 rd 0", rd_data_o, 8'h00);
  endtask

  task automatic t_cmp_set();
    wr(8'h20);
    cmp_i = 2'b01; step();
    chk("R3 set", {7'b0, latch_q_o}, 8'h01);
    cmp_i = 2'b00; step(); step();
    chk("R12 hold 1", {7'b0, latch_q_o}, 8'h01);
  endtask

  task automatic t_cmp_reset();
    wr(8'h30);
    cmp_i = 2'b10; step();
    chk("R5 reset", {7'b0, latch_q_o}, 8'h00);
    cmp_i = 2'b00; step();
    chk("R12 hold 0", {7'b0, latch_q_o}, 8'h00);
  endtask

  task automatic t_disabled();
    wr(8'h00);
    cmp_i = 2'b01; step(); step();
    chk("R4 no set", {7'b0, latch_q_o}, 8'h00);
    cmp_i = 2'b00;
    wr(8'h08); step();
    chk("R7 precond", {7'b0, latch_q_o}, 8'h01);
    cmp_i = 2'b10; step(); step();
    chk("R6 no reset", {7'b0, latch_q_o}, 8'h01);
    cmp_i = 2'b00;
  endtask

  task automatic t_pulse();
    wr(8'h04);
    chk("R8 not yet", {7'b0, latch_q_o}, 8'h01);
    step();
    chk("R8 cleared", {7'b0, latch_q_o}, 8'h00);
    wr(8'h08);
    chk("R7 not yet", {7'b0, latch_q_o}, 8'h00);
    chk("R7 rd zero", rd_data_o, 8'h00);
    step();
    chk("R7 set", {7'b0, latch_q_o}, 8'h01);
    wr(8'h00); step();
    chk("R7 zero write", {7'b0, latch_q_o}, 8'h01);
  endtask

  task automatic t_priority();
    wr(8'h30);
    cmp_i = 2'b11; step();
    chk("R9 cmp both", {7'b0, latch_q_o}, 8'h00);
    cmp_i = 2'b10;
    wr(8'h38); step();
    chk("R9 pulse vs cmp", {7'b0, latch_q_o}, 8'h00);
    cmp_i = 2'b00;
    wr(8'h08); step();
    chk("R7 reset ok", {7'b0, latch_q_o}, 8'h01);
  endtask

  task automatic t_pinmux();
    wr(8'h40);
    cmp_i = 2'b00; #1;
    chk("R10 pin0 q", {6'b0, pin_o}, 8'h01);
    cmp_i = 2'b10; #1;
    chk("R10 pin1 cmp", {6'b0, pin_o}, 8'h03);
    chk("R11 status", {6'b0, cmp_status_o}, 8'h02);
    step();
    wr(8'h80);
    cmp_i = 2'b01; #1;
    chk("R10 swap", {6'b0, pin_o}, 8'h03);
    cmp_i = 2'b00; #1;
    chk("R10 swap lo", {6'b0, pin_o}, 8'h02);
    chk("R11 status lo", {6'b0, cmp_status_o}, 8'h00);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    step(); step();
    t_reset();
    rst_ni = 1'b1;
    step();
    t_readback();
    t_cmp_set();
    t_cmp_reset();
    t_disabled();
    t_pulse();
    t_priority();
    t_pinmux();
    done = 1;
    finish_run();
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule